// File: doc/BRIEF.md
# Signed Voltage ASCII Formatter

This block turns one offset-binary conversion code into a human-readable signed voltage line and streams that line out as ASCII bytes, one at a time, over a valid/ready byte interface sized to feed a serial transmitter. The code covers a symmetric span of -5 V to +5 V. Mid-scale means zero volts. Codes below mid-scale are negative.

A conversion starts with a one-cycle `start_i` pulse that carries `code_i`. The block takes the distance of the code from mid-scale and multiplies it by an exact integer step, 390625, counted in units of 1e-7 V. This gives a fixed-point value with seven fractional decimal places. A sequential restoring divide-by-ten loop then peels off the decimal digits, least significant first, and stacks them. The stack is read back in reverse order, so the most significant digit goes out first. The line is a sign character, three integer digits, a point, seven fractional digits, the text " volts", and then CR and LF.

Top module: `volt_ascii_fmt`

## Requirements
- R1: After reset, `tx_valid_o` is 0 and `busy_o` is 0.
- R2: A `start_i` pulse is taken only while `busy_o` is 0. A pulse while busy is ignored: the line being produced still shows the code captured first.
- R3: The first byte is '-' (0x2D) when `code_i` < 128 and a space (0x20) otherwise. Code 128 prints as a space followed by all-zero digits.
- R4: The printed magnitude is |code − 128| × 390625 in units of 1e-7 V. It is written as three integer digits, '.' (0x2E), and seven fractional digits. Leading zeros are kept, and each digit d is sent as 0x30 + d.
- R5: After the last fractional digit come the eight bytes " volts" (0x20 0x76 0x6F 0x6C 0x74 0x73), CR (0x0D) and LF (0x0A). A line is exactly 20 bytes long.
- R6: While `tx_valid_o` is 1 and `tx_ready_i` is 0, `tx_valid_o` stays 1 and `tx_data_o` holds its value. Each byte is transferred exactly once, on a cycle where both are 1.
- R7: After the handshake of the final LF, `tx_valid_o` goes to 0 and `busy_o` goes to 0 on the next cycle, and a new start is accepted.
- R8: Each digit is the remainder of a restoring division by ten, and that remainder is always below ten.
- R9: The digit stack never overflows or underflows. It holds all ten digits when sending begins and is empty after the last byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | One-cycle request to format `code_i` |
| code_i | input | 8 | Offset-binary code, 128 = 0 V |
| busy_o | output | 1 | High from accepted start to end of line |
| tx_data_o | output | 8 | ASCII byte being offered |
| tx_valid_o | output | 1 | `tx_data_o` holds a byte to send |
| tx_ready_i | input | 1 | Sink accepts the byte this cycle |

## Verification
The assertions check on every cycle that an offered byte holds still under backpressure, that the divider never yields a remainder of ten or more, and that the digit stack is never pushed when full or popped when empty. They also check that the stack is full as sending begins and empty once the last byte has left. Only the bench scenarios can show that the bytes are right: the sign for codes on each side of mid-scale, the scaled digits at the end codes and near mid-scale, the fixed text tail, and that a start arriving mid-line leaves the captured code alone.

// File: rtl/voltfmt_pkg.sv
package voltfmt_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_DIV_GO,
    ST_DIV_WAIT,
    ST_SEND
  } fmt_state_e;

  localparam logic [7:0] CH_MINUS = 8'h2D;
  localparam logic [7:0] CH_SPACE = 8'h20;
  localparam logic [7:0] CH_POINT = 8'h2E;
  localparam int TAIL_LEN = 8;

  function automatic logic [7:0] digit_ascii(input logic [3:0] d);
    return 8'h30 + {4'h0, d};
  endfunction

  // Fixed tail: " volts" CR LF
  function automatic logic [7:0] tail_ascii(input logic [3:0] k);
    case (k)
      4'd0:    return 8'h20;
      4'd1:    return 8'h76;
      4'd2:    return 8'h6F;
      4'd3:    return 8'h6C;
      4'd4:    return 8'h74;
      4'd5:    return 8'h73;
      4'd6:    return 8'h0D;
      default: return 8'h0A;
    endcase
  endfunction

endpackage

// File: rtl/div10_restoring.sv
module div10_restoring #(
  parameter int W = 26
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [W-1:0] dividend,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] quot,
  output logic [3:0]   rem
);
  localparam int CNT_W = $clog2(W + 1);

  logic [CNT_W-1:0] cnt_q;
  logic [W-1:0]     q_q;
  logic [3:0]       r_q;
  logic [4:0]       trial;
  logic             fits;

  // One quotient bit per cycle: shift in next dividend bit, try subtracting ten
  assign trial = {r_q, q_q[W-1]};
  assign fits  = (trial >= 5'd10);
  assign busy  = (cnt_q != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      q_q   <= '0;
      r_q   <= '0;
      done  <= 1'b0;
    end else if (start && !busy) begin
      cnt_q <= CNT_W'(W);
      q_q   <= dividend;
      r_q   <= '0;
      done  <= 1'b0;
    end else if (busy) begin
      q_q   <= {q_q[W-2:0], fits};
      r_q   <= fits ? 4'(trial - 5'd10) : trial[3:0];
      cnt_q <= cnt_q - 1'b1;
      done  <= (cnt_q == CNT_W'(1));
    end else begin
      done  <= 1'b0;
    end
  end

  assign quot = q_q;
  assign rem  = r_q;

  assert_rem_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (rem < 4'd10));

  assert_start_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !busy);

endmodule

// File: rtl/digit_lifo.sv
module digit_lifo #(
  parameter int DEPTH = 10,
  parameter int DW    = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [DW-1:0] push_data,
  input  logic          pop,
  output logic [DW-1:0] top_data,
  output logic          full,
  output logic          empty
);
  localparam int PTR_W  = $clog2(DEPTH + 1);
  localparam int ADDR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DW-1:0]    mem [DEPTH];
  logic [PTR_W-1:0] ptr_q;
  logic [ADDR_W-1:0] top_addr;

  assign full     = (ptr_q == PTR_W'(DEPTH));
  assign empty    = (ptr_q == '0);
  assign top_addr = ADDR_W'(ptr_q - PTR_W'(1));
  assign top_data = empty ? '0 : mem[top_addr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
    end else if (push && !full) begin
      ptr_q <= ptr_q + PTR_W'(1);
    end else if (pop && !empty) begin
      ptr_q <= ptr_q - PTR_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (push && !full) begin
      mem[ADDR_W'(ptr_q)] <= push_data;
    end
  end

  assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);

  assert_no_underflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);

endmodule

// File: rtl/volt_ascii_fmt.sv
module volt_ascii_fmt
  import voltfmt_pkg::*;
#(
  parameter int CODE_W      = 8,
  parameter int STEP        = 390625,
  parameter int INT_DIGITS  = 3,
  parameter int FRAC_DIGITS = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [CODE_W-1:0] code_i,
  output logic              busy_o,
  output logic [7:0]        tx_data_o,
  output logic              tx_valid_o,
  input  logic              tx_ready_i
);
  localparam int    MID       = 1 << (CODE_W - 1);
  localparam int    NDIG      = INT_DIGITS + FRAC_DIGITS;
  localparam longint MAX_VAL  = longint'(MID) * longint'(STEP);
  localparam int    VAL_W     = $clog2(MAX_VAL + 1);
  localparam int    FRAME_LEN = 1 + NDIG + 1 + TAIL_LEN;
  localparam int    IDX_W     = $clog2(FRAME_LEN);
  localparam int    CNT_W     = $clog2(NDIG + 1);
  localparam int    POINT_POS = INT_DIGITS + 1;
  localparam int    TAIL_POS  = NDIG + 2;

  fmt_state_e        state_q;
  logic              neg_q;
  logic [VAL_W-1:0]  work_q;
  logic [CNT_W-1:0]  dig_cnt_q;
  logic [IDX_W-1:0]  idx_q;

  // Arithmetic front end
  function automatic logic [CODE_W-1:0] offset_mag(input logic [CODE_W-1:0] c);
    return (c >= CODE_W'(MID)) ? (c - CODE_W'(MID)) : (CODE_W'(MID) - c);
  endfunction

  logic [CODE_W-1:0] mag;
  logic [VAL_W-1:0]  scaled;
  assign mag    = offset_mag(code_i);
  assign scaled = VAL_W'(mag) * VAL_W'(STEP);

  // Named events
  logic accept_start, div_start, div_busy, div_done, last_digit;
  logic send_enter, fire, last_byte, digit_pos;
  logic [VAL_W-1:0] div_quot;
  logic [3:0]       div_rem;
  logic [3:0]       top_digit;
  logic             lifo_full, lifo_empty;

  assign accept_start = (state_q == ST_IDLE) && start_i;
  assign div_start    = (state_q == ST_DIV_GO);
  assign last_digit   = (dig_cnt_q == CNT_W'(NDIG - 1));
  assign send_enter   = (state_q == ST_DIV_WAIT) && div_done && last_digit;
  assign tx_valid_o   = (state_q == ST_SEND);
  assign fire         = tx_valid_o && tx_ready_i;
  assign last_byte    = (idx_q == IDX_W'(FRAME_LEN - 1));
  assign digit_pos    = ((idx_q >= IDX_W'(1)) && (idx_q <= IDX_W'(INT_DIGITS))) ||
                        ((idx_q >= IDX_W'(POINT_POS + 1)) && (idx_q <= IDX_W'(NDIG + 1)));
  assign busy_o       = (state_q != ST_IDLE);

  div10_restoring #(.W(VAL_W)) u_div (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (div_start),
    .dividend (work_q),
    .busy     (div_busy),
    .done     (div_done),
    .quot     (div_quot),
    .rem      (div_rem)
  );

  digit_lifo #(.DEPTH(NDIG), .DW(4)) u_stack (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      ((state_q == ST_DIV_WAIT) && div_done),
    .push_data (div_rem),
    .pop       (fire && digit_pos),
    .top_data  (top_digit),
    .full      (lifo_full),
    .empty     (lifo_empty)
  );

  // Byte selection by frame position
  always_comb begin
    if (idx_q == '0) begin
      tx_data_o = neg_q ? CH_MINUS : CH_SPACE;
    end else if (digit_pos) begin
      tx_data_o = digit_ascii(top_digit);
    end else if (idx_q == IDX_W'(POINT_POS)) begin
      tx_data_o = CH_POINT;
    end else begin
      tx_data_o = tail_ascii(4'(idx_q - IDX_W'(TAIL_POS)));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      neg_q     <= 1'b0;
      work_q    <= '0;
      dig_cnt_q <= '0;
      idx_q     <= '0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (accept_start) begin
            neg_q     <= (code_i < CODE_W'(MID));
            work_q    <= scaled;
            dig_cnt_q <= '0;
            state_q   <= ST_DIV_GO;
          end
        end
        ST_DIV_GO: state_q <= ST_DIV_WAIT;
        ST_DIV_WAIT: begin
          if (div_done) begin
            work_q    <= div_quot;
            dig_cnt_q <= dig_cnt_q + CNT_W'(1);
            if (last_digit) begin
              idx_q   <= '0;
              state_q <= ST_SEND;
            end else begin
              state_q <= ST_DIV_GO;
            end
          end
        end
        default: begin
          if (fire) begin
            if (last_byte) begin
              state_q <= ST_IDLE;
            end else begin
              idx_q <= idx_q + IDX_W'(1);
            end
          end
        end
      endcase
    end
  end

  assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid_o && !tx_ready_i) |=> (tx_valid_o && $stable(tx_data_o)));

  assert_valid_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid_o |-> busy_o);

  assert_end_empty_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && last_byte) |=> (lifo_empty && !tx_valid_o && !busy_o));

  assert_full_at_send_R9: assert property (@(posedge clk) disable iff (!rst_n)
    send_enter |=> lifo_full);

  assert_div_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid_o |-> !div_busy);

endmodule

// File: tb/sim_volt_ascii_fmt.sv
`timescale 1ns/1ps
module sim_volt_ascii_fmt;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start_i = 1'b0;
  logic [7:0] code_i = 8'h00;
  logic       tx_ready_i = 1'b0;
  logic       busy_o, tx_valid_o;
  logic [7:0] tx_data_o;

  int n_checks = 0;
  int n_fails  = 0;
  int cycles   = 0;

  always #10 clk = ~clk;

  volt_ascii_fmt u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .code_i(code_i),
    .busy_o(busy_o), .tx_data_o(tx_data_o), .tx_valid_o(tx_valid_o),
    .tx_ready_i(tx_ready_i)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      n_fails = n_fails + 1;
      $display("FAIL watchdog: run hung, got %0d cycles expected under 150000", cycles);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks + 1, n_fails);
      $finish;
    end
  end

  function automatic string expect_line(input logic [7:0] c);
    int mag;
    longint v;
    string s;
    mag = (c < 8'd128) ? (128 - int'(c)) : (int'(c) - 128);
    v = longint'(mag) * 64'd390625;
    s = $sformatf("%s%03d.%07d volts", (c < 8'd128) ? "-" : " ",
                  v / 64'd10000000, v % 64'd10000000);
    return s;
  endfunction

  task automatic check_eq(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic pulse_start(input logic [7:0] c);
    @(negedge clk);
    while (busy_o) @(negedge clk);
    code_i  = c;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  // Collects one 20-byte line; mode 0 = always ready, mode 1 = ready one cycle in three
  task automatic collect_check(input logic [7:0] exp_code, input int mode, input string req);
    logic [7:0] got [20];
    string exp_s;
    logic [7:0] exp_b [20];
    int n, bad_pos, t;
    logic prev_stall;
    logic [7:0] prev_data;
    exp_s = expect_line(exp_code);
    for (int i = 0; i < 18; i++) exp_b[i] = exp_s[i];
    exp_b[18] = 8'h0D;
    exp_b[19] = 8'h0A;
    n = 0; t = 0; prev_stall = 1'b0; prev_data = 8'h00;
    while (n < 20 && t < 4000) begin
      @(negedge clk);
      t++;
      if (prev_stall) begin
        check_eq("R6 hold under backpressure", {tx_valid_o, tx_data_o}, {1'b1, prev_data});
      end
      tx_ready_i = (mode == 0) ? 1'b1 : ((t % 3) == 0);
      #1;
      if (tx_valid_o && tx_ready_i) begin
        got[n] = tx_data_o;
        n++;
      end
      prev_stall = tx_valid_o && !tx_ready_i;
      prev_data  = tx_data_o;
    end
    check_eq({req, " line length R5"}, n, 20);
    bad_pos = -1;
    for (int i = 0; i < n; i++) if (bad_pos < 0 && got[i] != exp_b[i]) bad_pos = i;
    n_checks++;
    if (bad_pos >= 0) begin
      n_fails++;
      $display("FAIL %s code %0d byte %0d: actual %02h expected %02h",
               req, exp_code, bad_pos, got[bad_pos], exp_b[bad_pos]);
    end
    @(negedge clk);
    tx_ready_i = 1'b0;
    check_eq("R7 idle after line", {tx_valid_o, busy_o}, 2'b00);
  endtask

  task automatic t_reset;
    check_eq("R1 reset valid/busy", {tx_valid_o, busy_o}, 2'b00);
  endtask

  task automatic t_line(input logic [7:0] c, input int mode, input string req);
    pulse_start(c);
    collect_check(c, mode, req);
  endtask

  task automatic t_ignore_start;
    pulse_start(8'd200);
    repeat (3) @(negedge clk);
    check_eq("R2 busy during conversion", busy_o, 1);
    code_i = 8'd10; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    collect_check(8'd200, 0, "R2 start while busy ignored");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_line(8'd128, 0, "R3 R4 zero code");
    t_line(8'd0,   0, "R3 R4 R8 R9 most negative");
    t_line(8'd255, 0, "R4 R8 most positive");
    t_line(8'd127, 0, "R3 one step below mid");
    t_line(8'd129, 0, "R3 R4 one step above mid");
    t_line(8'd37,  1, "R4 R5 R6 backpressure");
    t_line(8'd173, 1, "R5 R6 backpressure");
    t_ignore_start();
    t_line(8'd64,  0, "R7 restart after line");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end
endmodule